// File: doc/BRIEF.md
# ADC Conversion Result Bank

This block holds the latest 10-bit conversion result for each channel of an analog-to-digital converter, along with one extra special-purpose channel. Software reads these results over a small 8-bit register bus. The converter side is a single store strobe that carries a channel index and a 10-bit result. The block keeps the result and raises a "result present" flag for that channel.

Each channel is seen as two read-only bytes. The upper byte gives the eight most significant result bits. The lower byte gives the two least significant result bits in its top positions, plus two status bits at the bottom: a present flag and an overrun flag. Reading the lower byte clears both status bits. The overrun flag records that a new result replaced an old one before software had read both bytes of the old one.

Read data is combinational: it follows the read strobe within the same cycle. Flag side effects take hold at the clock edge that ends the strobe cycle.

Top module: `adc_rb_bank`

## Requirements
- R1: Channel k (0 ≤ k ≤ NUM_CH) has its upper byte at bus address 2k. That byte returns result bits 9..2 in positions 7..0.
- R2: The lower byte of channel k is at address 2k+1. Result bits 1..0 appear in positions 7..6, and positions 5..2 always read 0.
- R3: Position 0 of the lower byte is the present flag. A store to the channel sets it to 1. A read of the lower byte clears it to 0.
- R4: Position 1 of the lower byte is the overrun flag. A store sets it to 1 when the previous result of that channel has not yet had both of its bytes read. Reading only one of the two bytes is not enough to prevent it.
- R5: A read of the lower byte clears the overrun flag. A read of the upper byte leaves both flags unchanged.
- R6: After reset, every byte reads 0. The first store after reset does not set overrun.
- R7: The special channel has index NUM_CH (addresses 2·NUM_CH and 2·NUM_CH+1). It behaves exactly like the ordinary channels.
- R8: Suppose a store and a lower-byte read hit the same channel in the same cycle. The read returns the old contents. Afterwards the new data is kept and the present flag is 1. The lower byte counts as read for the overrun decision.
- R9: Any cycle with the bus write strobe high is a write access. It is ignored: it returns 0 on the read data and changes no data or flags, even when the read strobe is also high.
- R10: Addresses at or above 2·(NUM_CH+1) read as 0. A store whose channel index exceeds NUM_CH changes nothing.
- R11: Read data is valid in the same cycle as the read strobe, and it is 0 when no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cv_we | input | 1 | Conversion result store strobe |
| cv_ch | input | CH_W | Channel index of the stored result |
| cv_data | input | RES_W | Conversion result |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe (ignored access) |
| bus_addr | input | ADDR_W | Register byte address |
| bus_rdata | output | 8 | Read data, combinational |

## Verification
A read result belongs to the same cycle as its strobe. The bench therefore drives each access just after a falling edge and samples the read data 1 ns later, before the next rising edge. Stores and flag clears take effect at that rising edge, so their effects are checked through a read issued in a later cycle and never in the strobe cycle itself. The collision case puts a store and a lower-byte read in one cycle. It expects the old byte in that cycle and the new result one access later.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    SEL_UPPER = 1'b0,
    SEL_LOWER = 1'b1
  } byte_sel_e;

  // lower byte layout: two result LSBs on top, zero pad, overrun, present
  function automatic logic [BYTE_W-1:0] pack_lower(input logic [1:0] lsbs,
                                                   input logic ovr,
                                                   input logic present);
    return {lsbs, 4'b0000, ovr, present};
  endfunction

endpackage

// File: rtl/adc_rb_decode.sv
module adc_rb_decode
  import adc_rb_pkg::*;
#(
  parameter int NCH    = 5,
  parameter int CH_W   = 3,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [CH_W-1:0]   ch,
  output byte_sel_e         sel
);

  localparam logic [ADDR_W-1:0] ADDR_END = ADDR_W'(2 * NCH);

  always_comb begin
    hit = (addr < ADDR_END);
    ch  = addr[CH_W:1];
    sel = addr[0] ? SEL_LOWER : SEL_UPPER;
  end

endmodule

// File: rtl/adc_rb_slot.sv
module adc_rb_slot
  import adc_rb_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              store,
  input  logic [RES_W-1:0]  store_data,
  input  logic              rd_upper,
  input  logic              rd_lower,
  output logic [BYTE_W-1:0] upper_byte,
  output logic [BYTE_W-1:0] lower_byte
);

  localparam int LSB_W = RES_W - BYTE_W;

  logic [RES_W-1:0] res_q;
  logic             present_q;
  logic             ovr_q;
  logic             up_seen_q;
  logic             lo_seen_q;
  logic             prev_consumed;

  // previous result fully read, counting a read in this very cycle
  assign prev_consumed = (up_seen_q | rd_upper) & (lo_seen_q | rd_lower);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q     <= '0;
      present_q <= 1'b0;
      ovr_q     <= 1'b0;
      up_seen_q <= 1'b1;
      lo_seen_q <= 1'b1;
    end else if (store) begin
      res_q     <= store_data;
      present_q <= 1'b1;
      ovr_q     <= (ovr_q & ~rd_lower) | ~prev_consumed;
      up_seen_q <= 1'b0;
      lo_seen_q <= 1'b0;
    end else begin
      if (rd_upper) up_seen_q <= 1'b1;
      if (rd_lower) begin
        lo_seen_q <= 1'b1;
        present_q <= 1'b0;
        ovr_q     <= 1'b0;
      end
    end
  end

  assign upper_byte = res_q[RES_W-1 -: BYTE_W];
  assign lower_byte = pack_lower(res_q[LSB_W-1:0], ovr_q, present_q);

endmodule

// File: rtl/adc_rb_bank.sv
module adc_rb_bank
  import adc_rb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int RES_W  = 10,
  parameter int ADDR_W = 8,
  parameter int CH_W   = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cv_we,
  input  logic [CH_W-1:0]   cv_ch,
  input  logic [RES_W-1:0]  cv_data,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_rdata
);

  localparam int NCH = NUM_CH + 1;

  logic              dec_hit;
  logic [CH_W-1:0]   dec_ch;
  byte_sel_e         dec_sel;
  logic              rd_en;
  logic [BYTE_W-1:0] up_b [NCH];
  logic [BYTE_W-1:0] lo_b [NCH];

  assign rd_en = bus_rd & ~bus_wr & dec_hit;

  adc_rb_decode #(
    .NCH   (NCH),
    .CH_W  (CH_W),
    .ADDR_W(ADDR_W)
  ) u_dec (
    .addr(bus_addr),
    .hit (dec_hit),
    .ch  (dec_ch),
    .sel (dec_sel)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_slot
    logic sel_here;
    assign sel_here = rd_en && (dec_ch == CH_W'(k));

    adc_rb_slot #(
      .RES_W(RES_W)
    ) u_slot (
      .clk       (clk),
      .rst       (rst),
      .store     (cv_we && (cv_ch == CH_W'(k))),
      .store_data(cv_data),
      .rd_upper  (sel_here && (dec_sel == SEL_UPPER)),
      .rd_lower  (sel_here && (dec_sel == SEL_LOWER)),
      .upper_byte(up_b[k]),
      .lower_byte(lo_b[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      for (int k = 0; k < NCH; k++) begin
        if (dec_ch == CH_W'(k))
          bus_rdata = (dec_sel == SEL_LOWER) ? lo_b[k] : up_b[k];
      end
    end
  end

endmodule

// File: rtl/adc_rb_chk.sv
module adc_rb_chk #(
  parameter int NUM_CH = 4,
  parameter int RES_W  = 10,
  parameter int ADDR_W = 8,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cv_we,
  input logic [CH_W-1:0]   cv_ch,
  input logic [RES_W-1:0]  cv_data,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata
);

  logic            mapped;
  logic            lower;
  logic            rd_ok;
  logic [CH_W-1:0] rd_ch;

  assign mapped = bus_addr < ADDR_W'(2 * (NUM_CH + 1));
  assign lower  = bus_addr[0];
  assign rd_ok  = bus_rd && !bus_wr && mapped;
  assign rd_ch  = bus_addr[CH_W:1];

  // R2
  a_r2_pad_zero: assert property (@(posedge clk) disable iff (rst)
    rd_ok && lower |-> bus_rdata[5:2] == 4'b0000);

  // R10
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rd && !mapped |-> bus_rdata == 8'h00);

  // R9 / R11
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd || bus_wr) |-> bus_rdata == 8'h00);

  // R3
  a_r3_present_after_store: assert property (@(posedge clk) disable iff (rst)
    rd_ok && lower && $past(cv_we) && ($past(cv_ch) == rd_ch) |-> bus_rdata[0]);

  // R1
  a_r1_upper_fresh: assert property (@(posedge clk) disable iff (rst)
    rd_ok && !lower && $past(cv_we) && ($past(cv_ch) == rd_ch)
    |-> bus_rdata == 8'($past(cv_data) >> (RES_W - 8)));

  // R5
  a_r5_lower_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_ok && lower && $past(bus_rd) && !$past(bus_wr) && ($past(bus_addr) == bus_addr)
    && !($past(cv_we) && ($past(cv_ch) == rd_ch)) |-> bus_rdata[1:0] == 2'b00);

endmodule

bind adc_rb_bank adc_rb_chk #(
  .NUM_CH(NUM_CH),
  .RES_W (RES_W),
  .ADDR_W(ADDR_W),
  .CH_W  (CH_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cv_we    (cv_we),
  .cv_ch    (cv_ch),
  .cv_data  (cv_data),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata)
);

// File: tb/adc_rb_bank_bench.sv
`timescale 1ns/1ps
module adc_rb_bank_bench;

  localparam int NUM_CH = 4;
  localparam int RES_W  = 10;
  localparam int ADDR_W = 8;
  localparam int CH_W   = $clog2(NUM_CH + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cv_we = 1'b0;
  logic [CH_W-1:0]   cv_ch = '0;
  logic [RES_W-1:0]  cv_data = '0;
  logic              bus_rd = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0]        bus_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  adc_rb_bank #(
    .NUM_CH(NUM_CH),
    .RES_W (RES_W),
    .ADDR_W(ADDR_W),
    .CH_W  (CH_W)
  ) u_adc_rb_bank (
    .clk      (clk),
    .rst      (rst),
    .cv_we    (cv_we),
    .cv_ch    (cv_ch),
    .cv_data  (cv_data),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic store(input int ch, input logic [RES_W-1:0] d);
    @(negedge clk);
    cv_we = 1'b1; cv_ch = CH_W'(ch); cv_data = d;
    @(negedge clk);
    cv_we = 1'b0;
  endtask

  task automatic rd(input int addr, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ADDR_W'(addr);
    #1 check(req, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic store_and_rd(input int ch, input logic [RES_W-1:0] d,
                              input logic [7:0] exp, input string req);
    @(negedge clk);
    cv_we = 1'b1; cv_ch = CH_W'(ch); cv_data = d;
    bus_rd = 1'b1; bus_addr = ADDR_W'(2 * ch + 1);
    #1 check(req, bus_rdata, exp);
    @(negedge clk);
    cv_we = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 2 * (NUM_CH + 1); a++) rd(a, 8'h00, "R6 reset zero");
  endtask

  task automatic t_basic;
    store(0, 10'h2D7);
    rd(0, 8'hB5, "R1 upper byte");
    rd(1, 8'hC1, "R2/R3 lower byte with present, no overrun on first store R6");
    rd(1, 8'hC0, "R3 present cleared by lower read");
  endtask

  task automatic t_overrun;
    store(1, 10'h155);
    store(1, 10'h0AA);
    rd(3, 8'h83, "R4 overrun after unread overwrite");
    rd(3, 8'h80, "R5 overrun cleared by lower read");
    rd(2, 8'h2A, "R1 upper after overwrite");
    store(2, 10'h3FF);
    rd(4, 8'hFF, "R1 upper all ones");
    store(2, 10'h001);
    rd(4, 8'h00, "R5 upper read keeps flags");
    rd(5, 8'h43, "R4 one byte read not enough");
    store(2, 10'h100);
    rd(5, 8'h01, "R4 no overrun after both bytes read");
    rd(4, 8'h40, "R1 upper of third result");
  endtask

  task automatic t_special;
    store(NUM_CH, 10'h3C3);
    rd(2 * NUM_CH, 8'hF0, "R7 special upper");
    rd(2 * NUM_CH + 1, 8'hC1, "R7 special lower");
  endtask

  task automatic t_collision;
    store(3, 10'h004);
    rd(6, 8'h01, "R1 upper before collision");
    store_and_rd(3, 10'h3FE, 8'h01, "R8 collision returns old lower");
    rd(7, 8'h81, "R8 store wins, lower read counts");
    store_and_rd(3, 10'h005, 8'h80, "R8 collision returns old lower");
    rd(7, 8'h43, "R8 overrun when upper unread");
    rd(6, 8'h01, "R8 new data kept");
  endtask

  task automatic t_writes;
    store(0, 10'h0F0);
    for (int a = 0; a < 2; a++) begin
      @(negedge clk);
      bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = ADDR_W'(a);
      #1 check("R9 write access returns zero", bus_rdata, 8'h00);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
    end
    rd(1, 8'h01, "R9 write left present flag");
    rd(0, 8'h3C, "R9 write left data");
  endtask

  task automatic t_unmapped;
    store(7, 10'h3FF);
    store(5, 10'h3FF);
    for (int a = 2 * (NUM_CH + 1); a < 16; a++) rd(a, 8'h00, "R10 unmapped zero");
    rd(7, 8'h40, "R10 bad index store ignored ch3");
    rd(2 * NUM_CH, 8'hF0, "R10 bad index store ignored special");
  endtask

  task automatic t_comb;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = 8'd0;
    #1 check("R11 no strobe reads zero", bus_rdata, 8'h00);
    bus_rd = 1'b1;
    #0.5 check("R11 same-cycle data", bus_rdata, 8'h3C);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_overrun();
    t_special();
    t_collision();
    t_writes();
    t_unmapped();
    t_comb();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
      end
      wait (done);
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule